// File: doc/BRIEF.md
# Fractional Tick-Rate Generator with Committed Updates

This block runs on one reference clock and produces a single-cycle enable strobe, `tick_en`. Downstream logic gates its registers with this strobe, so no clock is ever switched or gated. The reference is first halved into a base cadence, one base slot every second clock. A phase accumulator then lets through `mult` out of every 32 base slots, with `mult = 32 - code`. A code of 0 gives the full base rate, and a code of 31 gives one thirty-second of it.

Software reaches the block through one 32-bit control word on a plain register bus. Writing the 5-bit code only stages it. The running divider picks up the staged code after software sets the commit flag. The divider applies the new ratio at the next boundary of its 32-slot frame, and then hardware clears the flag. Software polls the flag to learn that the change is done. While the flag reads 1, the staged code is locked.

Top module: `frac_tick_gen`

## Requirements
- R1: A synchronous reset clears the whole control word to 0, holds `tick_en` low and restarts the prescaler, the accumulator and the frame counter. After reset the active code is 0 (full rate), giving 64 strobes in any 128 reference cycles.
- R2: With active code c held in bits 28:24, the number of strobes in any 128 consecutive reference cycles is exactly 2*(32-c), for every c from 0 to 31.
- R3: `tick_en` is high for one reference cycle at a time, only in a base slot, and never in two consecutive cycles.
- R4: A write to the control address with bit 31 set makes bit 31 read back as 1 on the next read.
- R5: Once bit 31 is set, hardware clears it within 66 reference cycles. It clears it exactly two cycles after the staged code is loaded at a frame boundary. From then on the new rate is in force.
- R6: Writing 0 to bit 31 has no effect. It neither clears a pending commit nor applies a staged code while idle.
- R7: While bit 31 reads 1, writes to bits 28:24 are ignored, and the code already staged is the one applied.
- R8: Bits 30:29 and 23:0 store whatever is written and read back unchanged.
- R9: The active ratio changes only at the end of a 32-slot frame, and every frame starts with the accumulator at zero. The strobe pattern is therefore exact cycle by cycle.
- R10: Read data is 0 when the read strobe is low or the address does not match. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational from the stored word |
| tick_en | output | 1 | Fractional-rate enable strobe |

## Verification
The hardest state to reach is a write that lands while a commit is still pending. Such a write may try to change the staged code, or may write 0 to the commit bit, and it arrives before the frame boundary has come around. The stimulus sets the commit bit and then immediately issues a second write, with a different code and with the commit bit either set or cleared. Tick counts and a per-cycle model then show which code actually took effect. The worst-case commit latency is covered by sweeping all 32 codes one after another. That sweep places the commit write at many different phases of the frame.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
   localparam int REG_W         = 32;
   localparam int DEF_CODE_W    = 5;
   localparam int DEF_FIELD_LSB = 24;
   localparam int DEF_KICK_POS  = 31;

   typedef logic [REG_W-1:0] reg_word_t;

   // mask of CW ones starting at bit LSB
   function automatic reg_word_t field_mask(input int lsb, input int cw);
      reg_word_t m;
      m = '0;
      for (int i = 0; i < cw; i++) m[lsb+i] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/frac_prescale.sv
module frac_prescale #(
   parameter int PRE_DIV = 2
) (
   input  logic clk,
   input  logic rst,
   output logic base_en
);
   generate
      if (PRE_DIV != 1 && PRE_DIV != 2) begin : g_bad
         $error("frac_prescale: PRE_DIV must be 1 or 2");
      end
      if (PRE_DIV == 2) begin : g_half
         logic half_q;
         always_ff @(posedge clk) begin
            if (rst) half_q <= 1'b0;
            else     half_q <= ~half_q;
         end
         assign base_en = half_q;
      end else begin : g_full
         assign base_en = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
   parameter int CODE_W = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              base_en,
   input  logic              load_en,
   input  logic [CODE_W-1:0] load_code,
   output logic              tick_en,
   output logic              frame_end
);
   localparam int MW    = CODE_W + 1;
   localparam int FRAME = 1 << CODE_W;

   generate
      if (CODE_W < 1 || CODE_W > 12) begin : g_bad
         $error("frac_phase_acc: CODE_W out of range");
      end
   endgenerate

   logic [MW-1:0]     mult_q;
   logic [CODE_W-1:0] acc_q;
   logic [CODE_W-1:0] frm_q;
   logic [MW-1:0]     sum;
   logic              wrap;
   logic              tick_q;

   assign sum       = {1'b0, acc_q} + mult_q;
   assign wrap      = sum[CODE_W];
   assign frame_end = base_en && (&frm_q);
   assign tick_en   = tick_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q  <= '0;
         frm_q  <= '0;
         tick_q <= 1'b0;
         mult_q <= MW'(FRAME);
      end else begin
         tick_q <= base_en && wrap;
         if (base_en) begin
            acc_q <= sum[CODE_W-1:0];
            frm_q <= frm_q + 1'b1;
         end
         if (load_en) mult_q <= MW'(FRAME) - MW'(load_code);
      end
   end

   // R9: a frame always begins from a zero phase
   a_r9_frame_starts_at_zero: assert property (@(posedge clk) disable iff (rst)
      (base_en && frm_q == '0) |-> (acc_q == '0));
   // R3: a strobe only follows a base slot
   a_r3_tick_on_base: assert property (@(posedge clk) disable iff (rst)
      tick_en |-> $past(base_en));
endmodule

// File: rtl/frac_ctrl_reg.sv
module frac_ctrl_reg
   import frac_clk_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0,
   parameter int CODE_W    = DEF_CODE_W,
   parameter int FIELD_LSB = DEF_FIELD_LSB,
   parameter int KICK_POS  = DEF_KICK_POS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [REG_W-1:0]  bus_wdata,
   input  logic              bus_rd,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              commit,
   output logic [CODE_W-1:0] code,
   output logic              kick
);
   localparam reg_word_t CODE_MASK = field_mask(FIELD_LSB, CODE_W);
   localparam reg_word_t KICK_MASK = field_mask(KICK_POS, 1);
   localparam reg_word_t KEEP_MASK = ~(CODE_MASK | KICK_MASK);

   generate
      if (FIELD_LSB + CODE_W > REG_W || KICK_POS >= REG_W) begin : g_bad_pos
         $error("frac_ctrl_reg: field does not fit the word");
      end
      if (KICK_POS >= FIELD_LSB && KICK_POS < FIELD_LSB + CODE_W) begin : g_overlap
         $error("frac_ctrl_reg: commit bit overlaps code field");
      end
   endgenerate

   reg_word_t reg_q, reg_nxt;
   logic      clr_q;
   logic      hit;

   assign hit  = (bus_addr == ADDR_W'(CTRL_ADDR));
   assign code = reg_q[FIELD_LSB +: CODE_W];
   assign kick = reg_q[KICK_POS];
   assign bus_rdata = (bus_rd && hit) ? reg_q : '0;

   always_comb begin
      reg_nxt = reg_q;
      if (bus_wr && hit) begin
         reg_nxt = (reg_nxt & ~KEEP_MASK) | (bus_wdata & KEEP_MASK);
         if (!kick) reg_nxt = (reg_nxt & ~CODE_MASK) | (bus_wdata & CODE_MASK);
         if (bus_wdata[KICK_POS]) reg_nxt[KICK_POS] = 1'b1;
      end
      if (clr_q) reg_nxt[KICK_POS] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         reg_q <= '0;
         clr_q <= 1'b0;
      end else begin
         reg_q <= reg_nxt;
         clr_q <= commit;
      end
   end

   // R7: staged code is locked while a commit is pending
   a_r7_code_locked: assert property (@(posedge clk) disable iff (rst)
      $past(kick) |-> $stable(code));
   // R5: the flag drops only two cycles after the load
   a_r5_clear_after_load: assert property (@(posedge clk) disable iff (rst)
      $fell(kick) |-> $past(commit, 2));
   // R4: the flag rises only from a matching write with the bit set
   a_r4_set_by_write: assert property (@(posedge clk) disable iff (rst)
      $rose(kick) |-> $past(bus_wr && hit && bus_wdata[KICK_POS]));
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
   import frac_clk_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int CTRL_ADDR = 0,
   parameter int CODE_W    = DEF_CODE_W,
   parameter int FIELD_LSB = DEF_FIELD_LSB,
   parameter int KICK_POS  = DEF_KICK_POS,
   parameter int PRE_DIV   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   output logic              tick_en
);
   logic              base_en;
   logic              frame_end;
   logic              kick;
   logic              commit;
   logic [CODE_W-1:0] code;

   assign commit = kick && frame_end;

   frac_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
      .clk(clk), .rst(rst), .base_en(base_en));

   frac_phase_acc #(.CODE_W(CODE_W)) u_acc (
      .clk(clk), .rst(rst), .base_en(base_en), .load_en(commit),
      .load_code(code), .tick_en(tick_en), .frame_end(frame_end));

   frac_ctrl_reg #(
      .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CODE_W(CODE_W),
      .FIELD_LSB(FIELD_LSB), .KICK_POS(KICK_POS)
   ) u_reg (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .commit(commit), .code(code), .kick(kick));

   generate
      if (PRE_DIV == 2) begin : g_chk_half
         // R3: strobes are isolated single cycles
         a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
            tick_en |=> !tick_en);
      end
   endgenerate
endmodule

// File: tb/frac_tick_gen_test.sv
`timescale 1ns/1ps
module frac_tick_gen_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b1;
   logic [31:0] bus_rdata;
   logic        tick_en;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit consec_seen = 0;

   always #10 clk = ~clk;

   frac_tick_gen uut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .tick_en(tick_en));

   // behavioural reference model, advanced on each rising edge
   int          m_ph, m_acc, m_frm, m_mult;
   bit          m_tick, m_pend;
   logic [31:0] m_reg;

   always @(posedge clk) begin
      if (rst) begin
         m_ph = 0; m_acc = 0; m_frm = 0; m_mult = 32;
         m_tick = 0; m_pend = 0; m_reg = '0;
      end else begin
         bit base, commit;
         logic [31:0] nreg;
         base   = (m_ph == 1);
         commit = m_reg[31] && base && (m_frm == 31);
         m_tick = base && (m_acc + m_mult >= 32);
         if (base) begin
            m_acc = (m_acc + m_mult) % 32;
            m_frm = (m_frm + 1) % 32;
         end
         if (commit) m_mult = 32 - int'(m_reg[28:24]);
         nreg = m_reg;
         if (bus_wr && bus_addr == 4'd0) begin
            nreg[30:29] = bus_wdata[30:29];
            nreg[23:0]  = bus_wdata[23:0];
            if (!m_reg[31]) nreg[28:24] = bus_wdata[28:24];
            if (bus_wdata[31]) nreg[31] = 1'b1;
         end
         if (m_pend) nreg[31] = 1'b0;
         m_pend = commit;
         m_reg  = nreg;
         m_ph   = 1 - m_ph;
      end
   end

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // R9/R10: cycle-exact comparison against the model, away from the edge
   always begin
      @(negedge clk);
      #1;
      if (!rst) begin
         logic [31:0] exp_rd;
         exp_rd = (bus_rd && bus_addr == 4'd0) ? m_reg : 32'd0;
         check(tick_en == m_tick, "R9 tick pattern", tick_en, m_tick);
         check(bus_rdata == exp_rd, "R10 read data", bus_rdata, exp_rd);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 4'd0;
   endtask

   task automatic read_now(output logic [31:0] v);
      #2;
      v = bus_rdata;
   endtask

   task automatic count_ticks(input int n, output int cnt);
      bit prev;
      cnt = 0; prev = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
         if (tick_en) cnt++;
         if (tick_en && prev) consec_seen = 1;
         prev = tick_en;
      end
   endtask

   task automatic wait_clear(output int n);
      n = 0;
      do begin
         @(negedge clk);
         #1;
         n++;
      end while (bus_rdata[31] && n < 300);
   endtask

   initial begin
      int cnt, lat;
      logic [31:0] v;
      repeat (3) @(negedge clk);
      check(tick_en == 1'b0, "R1 tick low in reset", tick_en, 0);
      rst = 1'b0;
      #2;
      check(bus_rdata == 32'd0, "R1 word after reset", bus_rdata, 0);
      count_ticks(128, cnt);
      check(cnt == 64, "R1 full rate after reset", cnt, 64);

      // R2/R5: sweep all codes
      for (int c = 0; c < 32; c++) begin
         wr_reg(4'd0, 32'h8000_0000 | (32'(c) << 24));
         wait_clear(lat);
         check(lat <= 66, "R5 commit latency", lat, 66);
         count_ticks(128, cnt);
         check(cnt == 2 * (32 - c), "R2 rate per code", cnt, 2 * (32 - c));
      end

      // R4/R7: second write while pending must not change staged code
      wr_reg(4'd0, 32'h8000_0000 | (32'd10 << 24));
      read_now(v);
      check(v[31] == 1'b1, "R4 flag reads set", v[31], 1);
      wr_reg(4'd0, 32'h8000_0000 | (32'd20 << 24));
      read_now(v);
      check(v[28:24] == 5'd10, "R7 staged code locked", v[28:24], 10);
      wait_clear(lat);
      check(lat <= 66, "R5 commit latency", lat, 66);
      count_ticks(128, cnt);
      check(cnt == 44, "R7 applied code is first one", cnt, 44);

      // R6: staging without the flag changes nothing
      wr_reg(4'd0, 32'd3 << 24);
      read_now(v);
      check(v == (32'd3 << 24), "R6 staged idle", v, 32'd3 << 24);
      count_ticks(128, cnt);
      check(cnt == 44, "R6 rate unchanged", cnt, 44);
      // R6: writing 0 to the flag while pending does not cancel it
      wr_reg(4'd0, 32'h8000_0000 | (32'd3 << 24));
      wr_reg(4'd0, 32'd3 << 24);
      read_now(v);
      check(v[31] == 1'b1, "R6 flag survives zero write", v[31], 1);
      wait_clear(lat);
      count_ticks(128, cnt);
      check(cnt == 58, "R5 new rate in force", cnt, 58);

      // R8: other bits are plain storage
      wr_reg(4'd0, 32'h6355_AA33);
      read_now(v);
      check(v == 32'h6355_AA33, "R8 readback", v, 32'h6355_AA33);

      // R10: decode and read strobe
      @(negedge clk);
      bus_rd = 1'b0;
      #2;
      check(bus_rdata == 32'd0, "R10 no read strobe", bus_rdata, 0);
      bus_rd = 1'b1; bus_addr = 4'd1;
      #2;
      check(bus_rdata == 32'd0, "R10 other address", bus_rdata, 0);
      wr_reg(4'd1, 32'h8000_0000);
      read_now(v);
      check(v == 32'h6355_AA33, "R10 foreign write ignored", v, 32'h6355_AA33);
      count_ticks(128, cnt);
      check(cnt == 58, "R10 rate unchanged", cnt, 58);

      check(consec_seen == 1'b0, "R3 no back-to-back strobes", consec_seen, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule